// File: doc/BRIEF.md
# Deep-Standby Power Sequencer

This block sequences a small processor subsystem into and out of a deep low-power state. When the CPU signals a sleep request while the standby-enable control is set, the sequencer drops the oscillator enable and every gated clock enable. It also drives the I/O ports into either a held or a high-impedance condition, as chosen by a control bit sampled at entry. The block itself runs on an always-available reference clock. The oscillator, the CPU and the exception logic are outside it and appear only as enable and request signals.

The block has two ways out of standby. The first is the chosen edge on the non-maskable interrupt input. This turns the oscillator back on and gates a clock to the watchdog counter only. The counter then runs a stabilisation delay whose length comes from a 3-bit select captured at entry. When the counter overflows, the full chip clock is released and a one-cycle NMI request is issued. The second way out is the active-low reset input going low. This releases all clocks immediately, with no delay. When the reset input rises again, a one-cycle reset request is issued.

Top module: `standby_ctrl`

## Requirements
- R1: In RUN, a one-cycle `sleep_req_i` with `stby_en_i`=1 moves the state to STANDBY on the next clock edge. In STANDBY, `osc_en_o`, `cpu_clk_en_o`, `per_clk_en_o` and `wdt_clk_en_o` are all 0.
- R2: A `sleep_req_i` with `stby_en_i`=0 has no effect: the state stays RUN and all clock enables stay 1.
- R3: `hiz_sel_i` is sampled on entry to standby. In STANDBY and STABILISE, a sampled value of 1 gives `port_hiz_o`=1 and `port_hold_o`=0, and a sampled value of 0 gives the reverse. In RUN and RESET_HOLD, both outputs are 0. Changes to `hiz_sel_i` after entry are ignored.
- R4: `nmi_edge_sel_i` is sampled on entry: 0 selects a falling edge and 1 selects a rising edge of `nmi_i`. An edge in the other direction leaves the state in STANDBY.
- R5: A selected edge on `nmi_i` moves the state to STABILISE on the third clock edge after the change (two synchroniser stages plus the state register). In STABILISE, `osc_en_o`=1, `wdt_clk_en_o`=1, `cpu_clk_en_o`=0 and `per_clk_en_o`=0.
- R6: STABILISE lasts exactly 2^(4+2·S)·256 cycles, where S is the value of `wdt_cks_i` sampled on entry to standby. Changes to `wdt_cks_i` during standby are ignored.
- R7: At the end of STABILISE, the state returns to RUN with all clocks enabled, and `nmi_req_o` is high for exactly one cycle: the first cycle of RUN.
- R8: If `res_ni` goes low during STANDBY or STABILISE, the state moves to RESET_HOLD on the third clock edge after the change, with no stabilisation delay. In RESET_HOLD, `osc_en_o`, `cpu_clk_en_o`, `per_clk_en_o` and `wdt_clk_en_o` are all 1.
- R9: When `res_ni` returns high in RESET_HOLD, the state moves to RUN on the third clock edge after the change. `rst_req_o` is high for exactly that first cycle of RUN, and `nmi_req_o` stays 0.
- R10: `state_o` encodes the state as RUN=0, STANDBY=1, STABILISE=2 and RESET_HOLD=3.
- R11: After `rst_ni` is released, the state is RUN, all clock enables are 1, and both request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| sleep_req_i | input | 1 | Sleep request from CPU, one cycle |
| stby_en_i | input | 1 | Standby-enable control bit |
| hiz_sel_i | input | 1 | Port mode in standby: 1 high-impedance, 0 held |
| nmi_edge_sel_i | input | 1 | NMI wake edge: 0 falling, 1 rising |
| wdt_cks_i | input | 3 | Stabilisation period select |
| nmi_i | input | 1 | Asynchronous non-maskable interrupt pin |
| res_ni | input | 1 | Asynchronous active-low reset pin |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| wdt_clk_en_o | output | 1 | Watchdog counter clock gate enable |
| port_hiz_o | output | 1 | I/O ports forced high-impedance |
| port_hold_o | output | 1 | I/O ports hold their last value |
| state_o | output | 2 | Current sequencer state |
| nmi_req_o | output | 1 | NMI exception request pulse |
| rst_req_o | output | 1 | Reset exception request pulse |

## Verification
The hardest case to reach from the ports is a reset wake that lands in the middle of a stabilisation count. Together with it comes a period select that changes while the block is already asleep. The bench reaches both with directed sequences. It lets the counter run for a fixed number of cycles after an NMI edge before pulling the reset pin low, and it moves `wdt_cks_i` between entry and the wake edge. Random rounds then vary the edge polarity, the port mode, a preceding wrong-direction edge and the wake source. For each round, the bench's own functions predict the stabilisation length.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_STANDBY    = 2'd1,
    ST_STABILISE  = 2'd2,
    ST_RESET_HOLD = 2'd3
  } sb_state_e;
endpackage

// File: rtl/sb_sync.sv
module sb_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sb_stab_timer.sv
module sb_stab_timer #(
  parameter int SEL_W    = 3,
  parameter int PRE_BASE = 4,
  parameter int PRE_STEP = 2,
  parameter int CNT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ovf_o
);
  localparam int PRE_W = PRE_BASE + PRE_STEP * ((1 << SEL_W) - 1);
  localparam int SH_W  = $clog2(PRE_W + 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  shamt;
  logic [PRE_W:0]   tap_one;
  logic [PRE_W-1:0] tap_last;
  logic             tick;

  always_comb begin
    shamt    = SH_W'(PRE_BASE + PRE_STEP * int'(sel_i));
    tap_one  = (PRE_W + 1)'(1) << shamt;
    tap_last = tap_one[PRE_W-1:0] - 1'b1;
  end

  assign tick  = run_i && (pre_q == tap_last);
  assign ovf_o = tick && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: prescaler never passes its tap, counter moves only on a tick
  a_r6_pre_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> pre_q <= tap_last);
  a_r6_cnt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick) |=> (!run_i || $stable(cnt_q)));
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int PRE_BASE = 4,
  parameter int PRE_STEP = 2,
  parameter int CNT_W    = 8,
  parameter int SYNC_N   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             stby_en_i,
  input  logic             hiz_sel_i,
  input  logic             nmi_edge_sel_i,
  input  logic [SEL_W-1:0] wdt_cks_i,
  input  logic             nmi_i,
  input  logic             res_ni,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             wdt_clk_en_o,
  output logic             port_hiz_o,
  output logic             port_hold_o,
  output logic [1:0]       state_o,
  output logic             nmi_req_o,
  output logic             rst_req_o
);
  sb_state_e        state_q, state_d;
  logic             nmi_s, res_s, ovf;
  logic             es_q, hiz_q, nmi_ref_q;
  logic [SEL_W-1:0] cks_q;
  logic             nmi_req_q, rst_req_q;
  logic             entering, nmi_hit;

  sb_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_nmi_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(nmi_i), .q_o(nmi_s));
  sb_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_res_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(res_ni), .q_o(res_s));

  sb_stab_timer #(.SEL_W(SEL_W), .PRE_BASE(PRE_BASE), .PRE_STEP(PRE_STEP),
                  .CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q == ST_STABILISE),
    .sel_i(cks_q), .ovf_o(ovf));

  assign entering = (state_q == ST_RUN) && sleep_req_i && stby_en_i;
  // selected edge: current level is the target, previous level was not
  assign nmi_hit  = (nmi_s == es_q) && (nmi_ref_q != es_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:        if (entering) state_d = ST_STANDBY;
      ST_STANDBY:    if (!res_s) state_d = ST_RESET_HOLD;
                     else if (nmi_hit) state_d = ST_STABILISE;
      ST_STABILISE:  if (!res_s) state_d = ST_RESET_HOLD;
                     else if (ovf) state_d = ST_RUN;
      ST_RESET_HOLD: if (res_s) state_d = ST_RUN;
      default:       state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      es_q      <= 1'b0;
      hiz_q     <= 1'b0;
      cks_q     <= '0;
      nmi_ref_q <= 1'b0;
      nmi_req_q <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      nmi_req_q <= (state_q == ST_STABILISE) && res_s && ovf;
      rst_req_q <= (state_q == ST_RESET_HOLD) && res_s;
      if (entering) begin
        es_q      <= nmi_edge_sel_i;
        hiz_q     <= hiz_sel_i;
        cks_q     <= wdt_cks_i;
        nmi_ref_q <= nmi_s;
      end else if (state_q == ST_STANDBY) begin
        nmi_ref_q <= nmi_s;
      end
    end
  end

  always_comb begin
    osc_en_o     = 1'b1;
    cpu_clk_en_o = 1'b1;
    per_clk_en_o = 1'b1;
    wdt_clk_en_o = 1'b1;
    port_hiz_o   = 1'b0;
    port_hold_o  = 1'b0;
    unique case (state_q)
      ST_STANDBY: begin
        osc_en_o     = 1'b0;
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        wdt_clk_en_o = 1'b0;
        port_hiz_o   = hiz_q;
        port_hold_o  = !hiz_q;
      end
      ST_STABILISE: begin
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        port_hiz_o   = hiz_q;
        port_hold_o  = !hiz_q;
      end
      default: ;
    endcase
  end

  assign state_o   = state_q;
  assign nmi_req_o = nmi_req_q;
  assign rst_req_o = rst_req_q;

  a_r1_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && sleep_req_i && stby_en_i) |=> state_o == 2'd1);
  a_r2_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !stby_en_i) |=> state_o == 2'd0);
  a_r7_nmi_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_req_o) |-> $past(state_o) == 2'd2 && state_o == 2'd0);
  a_r7_nmi_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |=> !nmi_req_o);
  a_r9_rst_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(state_o) == 2'd3 && state_o == 2'd0);
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nmi_req_o, rst_req_o}));
  a_r8_hold_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && !res_s) |=> state_o == 2'd3);
endmodule

// File: tb/standby_ctrl_tb_top.sv
`timescale 1ns/1ps
module standby_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep = 0, stby_en = 0, hiz_sel = 0, edge_sel = 0, nmi = 0, res_n = 1;
  logic [2:0] cks = 0;
  logic osc, cpu, per, wdt, hiz, hold, nmi_req, rst_req;
  logic [1:0] state;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  standby_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep), .stby_en_i(stby_en),
    .hiz_sel_i(hiz_sel), .nmi_edge_sel_i(edge_sel), .wdt_cks_i(cks),
    .nmi_i(nmi), .res_ni(res_n), .osc_en_o(osc), .cpu_clk_en_o(cpu),
    .per_clk_en_o(per), .wdt_clk_en_o(wdt), .port_hiz_o(hiz),
    .port_hold_o(hold), .state_o(state), .nmi_req_o(nmi_req),
    .rst_req_o(rst_req));

  function automatic int exp_period(int s);
    return 1 << (4 + 2 * s + 8);
  endfunction

  function automatic int clk_vec(int o, int c, int p, int w);
    return (o << 3) | (c << 2) | (p << 1) | w;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  int cur_clk;
  always_comb cur_clk = clk_vec(int'(osc), int'(cpu), int'(per), int'(wdt));

  // nmi is first brought to start_lvl so the synchronised level is settled
  task automatic enter(bit es, bit hz, int s, bit start_lvl);
    nmi = start_lvl;
    step(3);
    edge_sel = es; hiz_sel = hz; cks = 3'(s);
    stby_en = 1; sleep = 1;
    step(1);
    sleep = 0;
    chk("R1 state after sleep", state, 1);
    chk("R1 clocks off", cur_clk, 0);
    chk("R3 port hiz", hiz, hz);
    chk("R3 port hold", hold, !hz);
  endtask

  task automatic nmi_wake(bit es, int s);
    int n = 0;
    nmi = es;
    step(3);
    chk("R5 state stabilise", state, 2);
    chk("R5 clocks in stabilise", cur_clk, clk_vec(1, 0, 0, 1));
    while (state == 2 && n < 100000) begin
      n++;
      step(1);
    end
    chk("R6 stabilise length", n, exp_period(s));
    chk("R7 state run", state, 0);
    chk("R7 clocks on", cur_clk, 15);
    chk("R7 nmi request", nmi_req, 1);
    chk("R3 ports released", {hiz, hold}, 0);
    step(1);
    chk("R7 nmi one cycle", nmi_req, 0);
  endtask

  task automatic res_wake();
    res_n = 0;
    step(3);
    chk("R8 reset hold", state, 3);
    chk("R8 clocks on", cur_clk, 15);
    step(2);
    res_n = 1;
    step(3);
    chk("R9 state run", state, 0);
    chk("R9 reset request", rst_req, 1);
    chk("R9 no nmi request", nmi_req, 0);
    step(1);
    chk("R9 reset one cycle", rst_req, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    step(2);
    chk("R11 reset state", state, 0);
    chk("R11 clocks after reset", cur_clk, 15);
    chk("R11 no requests", {nmi_req, rst_req}, 0);
    rst_n = 1;
    step(2);
    chk("R11 run after release", state, 0);

    // R2: sleep without enable
    stby_en = 0; sleep = 1;
    step(1);
    sleep = 0;
    step(1);
    chk("R2 stays run", state, 0);
    chk("R2 clocks stay on", cur_clk, 15);

    // R10/R4 falling edge wake, held ports, cks 0
    enter(1'b0, 1'b0, 0, 1'b1);
    chk("R10 standby code", state, 1);
    nmi_wake(1'b0, 0);

    // R6: cks=1 latched, changed during standby; R3 hiz changed too
    enter(1'b1, 1'b1, 1, 1'b0);
    cks = 3'd0; hiz_sel = 0;
    step(2);
    chk("R3 hiz latched", hiz, 1);
    nmi_wake(1'b1, 1);

    // R4: opposite edge first, then selected edge
    enter(1'b1, 1'b0, 0, 1'b1);
    nmi = 0;
    step(6);
    chk("R4 wrong edge ignored", state, 1);
    nmi_wake(1'b1, 0);

    // R8: reset during stabilisation
    enter(1'b0, 1'b1, 0, 1'b1);
    nmi = 0;
    step(3);
    chk("R5 stabilise before reset", state, 2);
    step(100);
    res_wake();

    // R8: reset straight from standby
    enter(1'b1, 1'b0, 2, 1'b0);
    res_wake();

    // random rounds
    for (int i = 0; i < 5; i++) begin
      bit es = 1'($urandom);
      bit hz = 1'($urandom);
      bit wrong = 1'($urandom);
      bit by_res = 1'($urandom);
      int s = ($urandom % 4 == 0) ? 1 : 0;
      enter(es, hz, s, wrong ? es : !es);
      if (wrong) begin
        nmi = !es;
        step(5);
        chk("R4 random wrong edge", state, 1);
      end
      if (by_res) res_wake();
      else nmi_wake(es, s);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule